// File: doc/BRIEF.md
# Instruction Fetch Miss Recovery Controller

This block sits at the front of a five-stage pipeline and steers instruction fetch against a synchronous instruction cache. Each cycle it presents the program counter to the cache and advances it by one instruction. One cycle later the cache returns a word and a hit flag for that address. The returned word is always captured into the fetch/decode pipeline register. The address of every unstalled fetch is kept in a memory address register.

Fetching is speculative. The program counter has already moved past an address before that address is known to miss. When a miss is reported, the controller stalls the pipeline and steps the program counter back by one instruction. It marks the captured word as a bubble, pulses a squash so that decode discards its register reads, and issues a main-memory read of the missed address. When memory signals completion, the returned word is written into the cache for that address. Fetch then restarts at the same address, and that access now hits.

Top module: `fetch_miss_stall`

## Requirements
- R1: While reset is asserted, the cache address is the reset PC (default 0), no memory read is requested, no fill is issued, and stall, squash and the pipeline-register valid flag are all low.
- R2: In every cycle without stall, the cache address in the next cycle is the current cache address plus the instruction size (4 bytes by default).
- R3: On every clock edge, the pipeline register captures the cache data word, whether the access hit or missed. It also captures the memory address register as the PC of that word.
- R4: The memory address output equals the cache address of the most recent cycle in which stall was low. It is held while stall is high.
- R5: A pending lookup that hits sets the pipeline-register valid flag in the next cycle. Any other cycle clears it.
- R6: A pending lookup that misses raises stall in that same cycle. In the next cycle, the cache address equals the missed address, which is the current address minus the instruction size.
- R7: Squash is high for exactly one cycle: the cycle after a miss is detected.
- R8: From the cycle after a miss up to and including the cycle in which memory completion is seen, the memory read request and stall are high. During that time the memory address and the cache address are held at the missed address.
- R9: In the cycle in which completion is seen while a read is requested, the cache fill strobe is high. The fill address is the missed address and the fill data is the memory read data.
- R10: In the cycle after completion, the request is low, the cache address is the missed address, and a lookup is pending in the following cycle. With a filled cache, that lookup hits.
- R11: A completion strobe seen while no read is requested is ignored: no fill is issued and fetch is unaffected.
- R12: The cache hit flag is ignored in cycles with no pending lookup: the first cycle after reset, the whole memory wait, and the cycle right after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ic_addr_o | output | ADDR_W | Fetch address presented to the cache (the PC) |
| ic_rdata_i | input | DATA_W | Cache data word for the address presented the cycle before |
| ic_hit_i | input | 1 | Cache hit flag for the address presented the cycle before |
| fill_en_o | output | 1 | Cache fill write strobe |
| fill_addr_o | output | ADDR_W | Cache fill address (sets index and tag) |
| fill_data_o | output | DATA_W | Cache fill word |
| mem_req_o | output | 1 | Main-memory read request, held until completion |
| mem_addr_o | output | ADDR_W | Memory address register |
| mem_done_i | input | 1 | Memory read completion strobe |
| mem_rdata_i | input | DATA_W | Memory read data, valid with completion |
| ifid_instr_o | output | DATA_W | Fetch/decode pipeline register word |
| ifid_pc_o | output | ADDR_W | PC of the word in the pipeline register |
| ifid_valid_o | output | 1 | Pipeline register holds a good instruction |
| stall_o | output | 1 | Pipeline stall to the downstream stages |
| squash_o | output | 1 | Discard the decode-stage register reads |

## Verification
A miss is detected in the cycle its hit flag arrives, one cycle after the address was presented. Stall and fill respond in that same cycle. The rewound address, the memory request, squash and the new pipeline-register contents are all due one edge later. The bench runs a behavioural model that advances once per rising edge and computes these expected values from the requirements. It then compares every output at the falling edge, after the inputs for that cycle have settled. The combinational outputs (stall, fill) are therefore judged against the inputs of the same cycle, and the registered outputs against the inputs of the cycle before. Memory latencies of zero to several cycles, back-to-back misses, and completion strobes sent while no read is requested exercise each timing path.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

   typedef enum logic {
      FSU_RUN  = 1'b0,
      FSU_WAIT = 1'b1
   } fsu_state_t;

   typedef struct packed {
      logic advance;
      logic rewind;
      logic mar_load;
      logic valid_in;
   } fsu_ctl_t;

endpackage

// File: rtl/fsu_pc_reg.sv
module fsu_pc_reg #(
   parameter int unsigned            ADDR_W   = 32,
   parameter int unsigned            STEP     = 4,
   parameter logic [ADDR_W-1:0]      RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              rewind,
   output logic [ADDR_W-1:0] pc_o
);

   localparam int unsigned ALIGN_W = (STEP > 1) ? $clog2(STEP) : 0;
   localparam int unsigned HI_W    = ADDR_W - ALIGN_W;

   generate
      if (ALIGN_W > 0) begin : g_aligned
         logic [HI_W-1:0] hi_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q <= RESET_PC[ADDR_W-1:ALIGN_W];
            end else if (advance) begin
               hi_q <= hi_q + 1'b1;
            end else if (rewind) begin
               hi_q <= hi_q - 1'b1;
            end
         end

         assign pc_o = {hi_q, {ALIGN_W{1'b0}}};
      end else begin : g_byte
         logic [ADDR_W-1:0] pc_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pc_q <= RESET_PC;
            end else if (advance) begin
               pc_q <= pc_q + 1'b1;
            end else if (rewind) begin
               pc_q <= pc_q - 1'b1;
            end
         end

         assign pc_o = pc_q;
      end
   endgenerate

endmodule

// File: rtl/fsu_fetch_latch.sv
module fsu_fetch_latch #(
   parameter int unsigned       ADDR_W   = 32,
   parameter int unsigned       DATA_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fsu_pkg::fsu_ctl_t ctl,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] ic_rdata,
   output logic [ADDR_W-1:0] mar_o,
   output logic [DATA_W-1:0] ifid_instr_o,
   output logic [ADDR_W-1:0] ifid_pc_o,
   output logic              ifid_valid_o
);

   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] instr_q;
   logic [ADDR_W-1:0] ipc_q;
   logic              valid_q;

   // memory address register: tracks every unstalled fetch address
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q <= RESET_PC;
      end else if (ctl.mar_load) begin
         mar_q <= cur_pc;
      end
   end

   // pipeline register: word captured unconditionally, validity separate
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         instr_q <= '0;
         ipc_q   <= RESET_PC;
         valid_q <= 1'b0;
      end else begin
         instr_q <= ic_rdata;
         ipc_q   <= mar_q;
         valid_q <= ctl.valid_in;
      end
   end

   assign mar_o        = mar_q;
   assign ifid_instr_o = instr_q;
   assign ifid_pc_o    = ipc_q;
   assign ifid_valid_o = valid_q;

endmodule

// File: rtl/fsu_miss_ctrl.sv
module fsu_miss_ctrl (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ic_hit,
   input  logic              mem_done,
   output fsu_pkg::fsu_ctl_t ctl,
   output logic              stall_o,
   output logic              squash_o,
   output logic              mem_req_o,
   output logic              fill_en_o
);

   import fsu_pkg::*;

   fsu_state_t state_q;
   logic       lookup_q;
   logic       squash_q;
   logic       waiting;
   logic       miss_now;
   logic       stall;

   assign waiting  = (state_q == FSU_WAIT);
   assign miss_now = !waiting && lookup_q && !ic_hit;
   assign stall    = waiting || miss_now;

   always_comb begin
      ctl          = '0;
      ctl.advance  = !stall;
      ctl.rewind   = miss_now;
      ctl.mar_load = !stall;
      ctl.valid_in = !stall && lookup_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= FSU_RUN;
         lookup_q <= 1'b0;
         squash_q <= 1'b0;
      end else begin
         lookup_q <= !stall;
         squash_q <= miss_now;
         case (state_q)
            FSU_RUN:  if (miss_now) state_q <= FSU_WAIT;
            FSU_WAIT: if (mem_done) state_q <= FSU_RUN;
            default:  state_q <= FSU_RUN;
         endcase
      end
   end

   assign stall_o   = stall;
   assign squash_o  = squash_q;
   assign mem_req_o = waiting;
   assign fill_en_o = waiting && mem_done;

endmodule

// File: rtl/fetch_miss_stall.sv
module fetch_miss_stall #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       INSTR_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] ic_addr_o,
   input  logic [DATA_W-1:0] ic_rdata_i,
   input  logic              ic_hit_i,
   output logic              fill_en_o,
   output logic [ADDR_W-1:0] fill_addr_o,
   output logic [DATA_W-1:0] fill_data_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_done_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [DATA_W-1:0] ifid_instr_o,
   output logic [ADDR_W-1:0] ifid_pc_o,
   output logic              ifid_valid_o,
   output logic              stall_o,
   output logic              squash_o
);

   localparam int unsigned ALIGN_W = (INSTR_BYTES > 1) ? $clog2(INSTR_BYTES) : 0;

   generate
      if (INSTR_BYTES == 0 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_step
         $error("INSTR_BYTES must be a nonzero power of two");
      end
      if (ADDR_W <= ALIGN_W) begin : g_bad_addr
         $error("ADDR_W too small for INSTR_BYTES");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (ALIGN_W > 0) begin : g_chk_align
         if (RESET_PC[ALIGN_W-1:0] != '0) begin : g_bad_reset
            $error("RESET_PC must be instruction aligned");
         end
      end
   endgenerate

   fsu_pkg::fsu_ctl_t ctl;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] mar;

   fsu_miss_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ic_hit    (ic_hit_i),
      .mem_done  (mem_done_i),
      .ctl       (ctl),
      .stall_o   (stall_o),
      .squash_o  (squash_o),
      .mem_req_o (mem_req_o),
      .fill_en_o (fill_en_o)
   );

   fsu_pc_reg #(
      .ADDR_W   (ADDR_W),
      .STEP     (INSTR_BYTES),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (ctl.advance),
      .rewind  (ctl.rewind),
      .pc_o    (pc)
   );

   fsu_fetch_latch #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RESET_PC (RESET_PC)
   ) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl          (ctl),
      .cur_pc       (pc),
      .ic_rdata     (ic_rdata_i),
      .mar_o        (mar),
      .ifid_instr_o (ifid_instr_o),
      .ifid_pc_o    (ifid_pc_o),
      .ifid_valid_o (ifid_valid_o)
   );

   assign ic_addr_o   = pc;
   assign mem_addr_o  = mar;
   assign fill_addr_o = mar;
   assign fill_data_o = mem_rdata_i;

endmodule

// File: rtl/fsu_checker.sv
module fsu_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STEP   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ic_addr_o,
   input logic              fill_en_o,
   input logic [ADDR_W-1:0] fill_addr_o,
   input logic [DATA_W-1:0] fill_data_o,
   input logic              mem_req_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_done_i,
   input logic [DATA_W-1:0] mem_rdata_i,
   input logic              stall_o,
   input logic              squash_o
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   a_r2_advance : assert property (@(posedge clk) disable iff (!rst_n)
      !stall_o |=> ic_addr_o == $past(ic_addr_o) + STEP_V);

   a_r6_rewind : assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && !mem_req_o) |=> ic_addr_o == $past(ic_addr_o) - STEP_V);

   a_r7_squash_start : assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && !mem_req_o) |=> (squash_o && mem_req_o));

   a_r7_squash_once : assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |=> !squash_o);

   a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_done_i) |=> (mem_req_o && stall_o &&
         $stable(mem_addr_o) && $stable(ic_addr_o)));

   a_r9_fill : assert property (@(posedge clk) disable iff (!rst_n)
      fill_en_o |-> (mem_req_o && mem_done_i && fill_addr_o == mem_addr_o &&
         fill_data_o == mem_rdata_i));

   a_r10_resume : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_done_i) |=> (!mem_req_o && !stall_o &&
         ic_addr_o == $past(mem_addr_o)));

   a_r11_no_fill : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req_o |-> !fill_en_o);

endmodule

bind fetch_miss_stall fsu_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .STEP   (INSTR_BYTES)
) u_fsu_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ic_addr_o   (ic_addr_o),
   .fill_en_o   (fill_en_o),
   .fill_addr_o (fill_addr_o),
   .fill_data_o (fill_data_o),
   .mem_req_o   (mem_req_o),
   .mem_addr_o  (mem_addr_o),
   .mem_done_i  (mem_done_i),
   .mem_rdata_i (mem_rdata_i),
   .stall_o     (stall_o),
   .squash_o    (squash_o)
);

// File: tb/fetch_miss_stall_test.sv
module fetch_miss_stall_test;

   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ic_addr_o;
   logic [DW-1:0] ic_rdata_i;
   logic          ic_hit_i;
   logic          fill_en_o;
   logic [AW-1:0] fill_addr_o;
   logic [DW-1:0] fill_data_o;
   logic          mem_req_o;
   logic [AW-1:0] mem_addr_o;
   logic          mem_done_i = 1'b0;
   logic [DW-1:0] mem_rdata_i = '0;
   logic [DW-1:0] ifid_instr_o;
   logic [AW-1:0] ifid_pc_o;
   logic          ifid_valid_o;
   logic          stall_o;
   logic          squash_o;

   always #5 clk = ~clk;

   fetch_miss_stall uut (
      .clk(clk), .rst_n(rst_n),
      .ic_addr_o(ic_addr_o), .ic_rdata_i(ic_rdata_i), .ic_hit_i(ic_hit_i),
      .fill_en_o(fill_en_o), .fill_addr_o(fill_addr_o), .fill_data_o(fill_data_o),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_done_i(mem_done_i), .mem_rdata_i(mem_rdata_i),
      .ifid_instr_o(ifid_instr_o), .ifid_pc_o(ifid_pc_o), .ifid_valid_o(ifid_valid_o),
      .stall_o(stall_o), .squash_o(squash_o)
   );

   int total = 0;
   int bad   = 0;
   int fills = 0;

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a[15:0] ^ 16'hA5C3, a[15:0]};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- cache model: one-cycle synchronous lookup ----------------
   logic [255:0] filled;
   logic         c_hit;
   logic [DW-1:0] c_data;
   assign ic_hit_i   = c_hit;
   assign ic_rdata_i = c_data;

   initial begin
      filled = '1;
      filled[2]  = 1'b0;
      filled[3]  = 1'b0;
      filled[9]  = 1'b0;
      filled[20] = 1'b0;
      filled[21] = 1'b0;
      filled[40] = 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         c_hit  <= 1'b0;
         c_data <= '0;
      end else begin
         c_hit  <= filled[ic_addr_o[9:2]];
         c_data <= filled[ic_addr_o[9:2]] ? word_of(ic_addr_o) : ~word_of(ic_addr_o);
         if (fill_en_o) filled[fill_addr_o[9:2]] <= 1'b1;
      end
   end

   // ---------------- reference model ----------------
   logic [AW-1:0] m_pc, m_mar, m_ipc, m_missed;
   logic [DW-1:0] m_instr;
   logic          m_lp, m_wait, m_valid, m_sq, m_nolook, m_resume;

   always @(posedge clk) begin
      logic miss;
      miss = !m_wait && m_lp && !ic_hit_i;
      if (!rst_n) begin
         m_pc <= '0; m_mar <= '0; m_ipc <= '0; m_instr <= '0;
         m_lp <= 1'b0; m_wait <= 1'b0; m_valid <= 1'b0; m_sq <= 1'b0;
         m_nolook <= 1'b0; m_resume <= 1'b0; m_missed <= '0;
      end else begin
         m_instr  <= ic_rdata_i;
         m_ipc    <= m_mar;
         m_sq     <= miss;
         m_resume <= m_wait && mem_done_i;
         m_nolook <= !m_wait && !m_lp;
         if (m_wait) begin
            m_valid <= 1'b0;
            m_lp    <= 1'b0;
            if (mem_done_i) m_wait <= 1'b0;
         end else if (miss) begin
            m_valid  <= 1'b0;
            m_lp     <= 1'b0;
            m_wait   <= 1'b1;
            m_pc     <= m_pc - 4;
            m_missed <= m_pc - 4;
         end else begin
            m_valid <= m_lp;
            m_lp    <= 1'b1;
            m_mar   <= m_pc;
            m_pc    <= m_pc + 4;
         end
      end
   end

   // ---------------- memory responder and per-cycle compare ----------------
   int lat_tab [5] = '{0, 3, 1, 6, 2};
   int lat_i = 0;
   int cnt   = 0;
   int cyc   = 0;

   always @(negedge clk) begin
      logic e_miss, e_stall;
      cyc++;
      if (rst_n && mem_req_o) begin
         if (cnt >= lat_tab[lat_i % 5]) begin
            mem_done_i  = 1'b1;
            mem_rdata_i = word_of(mem_addr_o);
            cnt = 0;
            lat_i++;
         end else begin
            mem_done_i  = 1'b0;
            mem_rdata_i = 32'hDEAD_0000 | cyc;
            cnt++;
         end
      end else begin
         // spurious completions while nothing is requested (R11)
         mem_done_i  = (cyc % 13 == 7);
         mem_rdata_i = 32'hBAD0_0000 | cyc;
      end
      #1;
      e_miss  = !m_wait && m_lp && !ic_hit_i;
      e_stall = m_wait || e_miss;
      if (!rst_n) begin
         chk("R1", "ic_addr", ic_addr_o, 0);
         chk("R1", "mem_req", mem_req_o, 0);
         chk("R1", "fill_en", fill_en_o, 0);
         chk("R1", "stall", stall_o, 0);
         chk("R1", "squash", squash_o, 0);
         chk("R1", "ifid_valid", ifid_valid_o, 0);
      end else begin
         if (m_resume)
            chk("R10", "ic_addr after fill", ic_addr_o, m_missed);
         else if (m_nolook || m_wait)
            chk("R12", "ic_addr without lookup", ic_addr_o, m_pc);
         else
            chk("R2", "ic_addr", ic_addr_o, m_pc);
         chk("R3", "ifid_instr", ifid_instr_o, m_instr);
         chk("R3", "ifid_pc", ifid_pc_o, m_ipc);
         chk("R4", "mem_addr", mem_addr_o, m_mar);
         chk("R5", "ifid_valid", ifid_valid_o, m_valid);
         chk("R6", "stall", stall_o, e_stall);
         chk("R7", "squash", squash_o, m_sq);
         chk("R8", "mem_req", mem_req_o, m_wait);
         if (m_wait) begin
            chk("R8", "mem_addr held", mem_addr_o, m_missed);
            chk("R9", "fill_en", fill_en_o, mem_done_i);
            if (mem_done_i) begin
               chk("R9", "fill_addr", fill_addr_o, m_missed);
               chk("R9", "fill_data", fill_data_o, word_of(m_missed));
               fills++;
            end
         end else begin
            chk("R11", "fill_en idle", fill_en_o, 0);
         end
         if (m_resume)
            chk("R10", "req dropped", mem_req_o, 0);
      end
   end

   // ---------------- sequence and watchdog ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      #2;
      chk("R9", "fill count", fills, 6);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #50000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule